// File: doc/BRIEF.md
# Page-Table Walker for 64-bit Entries (Four-Level and Three-Level)

This block turns one virtual address into a physical address by reading 64-bit page-table entries from memory, one entry per read. It handles two hierarchies. The four-level hierarchy starts from the table base held in the translation-root input. The three-level hierarchy starts from a 4-entry top table with 32-byte alignment. The walk can stop early at a 1 GiB or 2 MiB leaf. Every entry fetch address is ANDed with an address-wrap mask. Bit 63 of an entry (no-execute) is never carried into a frame address.

A request is accepted while `req_ready` is high. The engine then issues single-beat reads on a request/valid memory port, one read outstanding at a time. It returns a one-cycle response carrying the physical address, a page-size code and a fault flag. When paging is off, the address passes through unchanged. A non-canonical address in four-level mode faults without any memory read.

The controller has four states:
- `ST_IDLE` waits for a request.
- `ST_ISSUE` drives one entry read.
- `ST_WAIT` waits for the read data.
- `ST_DONE` presents the response.

Its transitions are:
- IDLE→DONE, when paging is off or the address is non-canonical.
- IDLE→ISSUE, to start a walk.
- ISSUE→WAIT, always.
- WAIT→ISSUE, for a table pointer.
- WAIT→DONE, for a leaf or a non-present entry.
- DONE→IDLE, always.

Top module: `page_walk_engine`

## Requirements
- R1: With `paging_en` low, an accepted request makes no memory read. The next cycle gives `rsp_valid`=1, `rsp_paddr` equal to the request address, `rsp_fault`=0 and `rsp_size`=0.
- R2: In four-level mode (`long_mode`=1), an address whose bits 63:47 are not all equal gives a fault response in the next cycle, with no memory read.
- R3: In four-level mode, the first fetch address is `cr3` bits 51:12 plus VA[47:39]×8. Each following fetch address is entry bits 51:12 plus 8× the index. The indices are VA[38:30], then VA[29:21], then VA[20:12].
- R4: In three-level mode (`long_mode`=0), the first fetch address is (`cr3` with bits 4:0 cleared) plus VA[31:30]×8. Bit 7 of that top entry has no effect. The walk continues with VA[29:21] and then VA[20:12].
- R5: Every value on `mem_addr` is ANDed with `a20_mask`.
- R6: An entry with bit 0 clear, at any level, ends the walk with `rsp_fault`=1, and no further read is made.
- R7: In four-level mode, bit 7 set in the entry read second gives a 1 GiB leaf. `rsp_size`=2, and `rsp_paddr` is the entry with bits 29:0 and bit 63 cleared, ORed with VA[29:0].
- R8: Bit 7 set in the entry read before the last level gives a 2 MiB leaf. `rsp_size`=1, and `rsp_paddr` is the entry with bits 20:0 and bit 63 cleared, ORed with VA[20:0].
- R9: A last-level entry gives a 4 KiB page. `rsp_size`=0, and `rsp_paddr` is the entry with bits 11:0 and bit 63 cleared, ORed with VA[11:0].
- R10: `mem_req` is a one-cycle pulse, and at most one read is outstanding. `req_ready` is high only when idle. A request raised during a walk is ignored.
- R11: `rsp_valid` lasts one cycle. It rises in the cycle after the `mem_rvalid` that ends a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| req_vaddr | input | 64 | Virtual address to translate |
| cr3 | input | 64 | Translation root (top table base) |
| long_mode | input | 1 | 1 = four-level, 0 = three-level hierarchy |
| paging_en | input | 1 | 0 = address passes through |
| a20_mask | input | 64 | AND mask applied to every fetch address |
| mem_req | output | 1 | Entry read request (one-cycle pulse) |
| mem_addr | output | 64 | Entry read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read data |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 64 | Physical address |
| rsp_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| rsp_fault | output | 1 | Walk failed |

## Verification
Responses that need no memory read are due exactly one cycle after acceptance. For walked requests, each read request appears in the cycle after acceptance or after the previous `mem_rvalid`, and the response is due exactly one cycle after the final `mem_rvalid`. The bench records the cycle number of each acceptance and of each data return. It checks every response against those stamps. It compares every observed fetch address, in order, with a queue produced by a behavioural walk of the same memory image. The response latency is varied from one to three cycles, so the handshake is exercised across different gaps.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_t;

    localparam int unsigned PRESENT_BIT = 0;
    localparam int unsigned LARGE_BIT   = 7;
    localparam int unsigned NX_BIT      = 63;
endpackage

// File: rtl/pw_fetch_addr.sv
module pw_fetch_addr #(
    parameter int ENTRY_W    = 64,
    parameter int VA_W       = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 9,
    parameter int LEVELS     = 4,
    parameter int PAE_IDX_W  = 2
) (
    input  logic [ENTRY_W-1:0]          tbl_base,
    input  logic [VA_W-1:PAGE_SHIFT]    va_hi,
    input  logic [$clog2(LEVELS)-1:0]   level,
    input  logic                        short_top,
    input  logic [ENTRY_W-1:0]          wrap_mask,
    output logic [ENTRY_W-1:0]          fetch_addr
);
    localparam int LVL_W   = $clog2(LEVELS);
    localparam int ENT_SH  = 3;
    localparam int HI_W    = VA_W - PAGE_SHIFT;
    localparam int TOP_OFF = IDX_W * (LEVELS - 2);

    logic [IDX_W-1:0] lvl_idx [LEVELS];
    logic [HI_W-1:0]  va_rel;
    logic [IDX_W-1:0] idx_sel;

    assign va_rel = va_hi;

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign lvl_idx[g] = va_rel[IDX_W*g +: IDX_W];
    end

    always_comb begin
        if (short_top)
            idx_sel = {{(IDX_W-PAE_IDX_W){1'b0}}, va_rel[TOP_OFF +: PAE_IDX_W]};
        else
            idx_sel = lvl_idx[LVL_W'(level)];
        fetch_addr = (tbl_base + {{(ENTRY_W-IDX_W-ENT_SH){1'b0}}, idx_sel, {ENT_SH{1'b0}}})
                     & wrap_mask;
    end
endmodule

// File: rtl/pw_entry_decode.sv
module pw_entry_decode
    import pw_pkg::*;
#(
    parameter int ENTRY_W    = 64,
    parameter int PA_W       = 52,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 9,
    parameter int LEVELS     = 4
) (
    input  logic [ENTRY_W-1:0]        entry,
    input  logic [ENTRY_W-1:0]        vaddr,
    input  logic [$clog2(LEVELS)-1:0] level,
    input  logic                      four_level,
    output logic                      present,
    output logic                      is_leaf,
    output logic [ENTRY_W-1:0]        leaf_paddr,
    output logic [ENTRY_W-1:0]        next_base
);
    localparam int LVL_W   = $clog2(LEVELS);
    localparam int SH_W    = $clog2(ENTRY_W) + 1;
    localparam int BIG_TOP = LEVELS - 2;
    localparam logic [ENTRY_W-1:0] BASE_MASK =
        {{(ENTRY_W-PA_W){1'b0}}, {(PA_W-PAGE_SHIFT){1'b1}}, {PAGE_SHIFT{1'b0}}};
    localparam logic [ENTRY_W-1:0] ONE = {{(ENTRY_W-1){1'b0}}, 1'b1};

    logic [SH_W-1:0]    shamt;
    logic [ENTRY_W-1:0] off_mask;
    logic               large_ok;

    always_comb begin
        present   = entry[PRESENT_BIT];
        large_ok  = (level != '0) &&
                    ((int'(level) < BIG_TOP) || (int'(level) == BIG_TOP && four_level));
        is_leaf   = (level == '0) || (entry[LARGE_BIT] && large_ok);
        shamt     = SH_W'(PAGE_SHIFT) + SH_W'(IDX_W) * SH_W'(level);
        off_mask  = (ONE << shamt) - ONE;
        leaf_paddr = (entry & ~off_mask & ~(ONE << NX_BIT)) | (vaddr & off_mask);
        next_base = entry & BASE_MASK;
    end
endmodule

// File: rtl/page_walk_engine.sv
module page_walk_engine
    import pw_pkg::*;
#(
    parameter int ENTRY_W    = 64,
    parameter int VA_W       = 48,
    parameter int PA_W       = 52,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 9,
    parameter int LEVELS     = 4,
    parameter int PAE_IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ENTRY_W-1:0]        req_vaddr,
    input  logic [ENTRY_W-1:0]        cr3,
    input  logic                      long_mode,
    input  logic                      paging_en,
    input  logic [ENTRY_W-1:0]        a20_mask,
    output logic                      mem_req,
    output logic [ENTRY_W-1:0]        mem_addr,
    input  logic                      mem_rvalid,
    input  logic [ENTRY_W-1:0]        mem_rdata,
    output logic                      rsp_valid,
    output logic [ENTRY_W-1:0]        rsp_paddr,
    output logic [$clog2(LEVELS)-1:0] rsp_size,
    output logic                      rsp_fault
);
    localparam int LVL_W     = $clog2(LEVELS);
    localparam int TOP_ALIGN = PAE_IDX_W + 3;
    localparam logic [LVL_W-1:0] LONG_TOP  = LVL_W'(LEVELS - 1);
    localparam logic [LVL_W-1:0] SHORT_TOP = LVL_W'(LEVELS - 2);
    localparam logic [ENTRY_W-1:0] ROOT_MASK =
        {{(ENTRY_W-PA_W){1'b0}}, {(PA_W-PAGE_SHIFT){1'b1}}, {PAGE_SHIFT{1'b0}}};
    localparam logic [ENTRY_W-1:0] SHORT_ROOT_MASK =
        {{(ENTRY_W-TOP_ALIGN){1'b1}}, {TOP_ALIGN{1'b0}}};

    walk_state_t          state_q, state_d;
    logic [LVL_W-1:0]     level_q;
    logic [ENTRY_W-1:0]   base_q;
    logic [ENTRY_W-1:0]   vaddr_q;
    logic                 four_q;
    logic [ENTRY_W-1:0]   paddr_q;
    logic [LVL_W-1:0]     size_q;
    logic                 fault_q;

    logic                 canon;
    logic                 ent_present, ent_leaf;
    logic [ENTRY_W-1:0]   ent_paddr, ent_next;
    logic [ENTRY_W-1:0]   fetch_addr;

    assign canon = (&req_vaddr[ENTRY_W-1:VA_W-1]) | ~(|req_vaddr[ENTRY_W-1:VA_W-1]);

    pw_fetch_addr #(
        .ENTRY_W(ENTRY_W), .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT),
        .IDX_W(IDX_W), .LEVELS(LEVELS), .PAE_IDX_W(PAE_IDX_W)
    ) u_fetch (
        .tbl_base  (base_q),
        .va_hi     (vaddr_q[VA_W-1:PAGE_SHIFT]),
        .level     (level_q),
        .short_top (!four_q && level_q == SHORT_TOP),
        .wrap_mask (a20_mask),
        .fetch_addr(fetch_addr)
    );

    pw_entry_decode #(
        .ENTRY_W(ENTRY_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT),
        .IDX_W(IDX_W), .LEVELS(LEVELS)
    ) u_decode (
        .entry     (mem_rdata),
        .vaddr     (vaddr_q),
        .level     (level_q),
        .four_level(four_q),
        .present   (ent_present),
        .is_leaf   (ent_leaf),
        .leaf_paddr(ent_paddr),
        .next_base (ent_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)
                          state_d = (!paging_en || (long_mode && !canon)) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (mem_rvalid)
                          state_d = (!ent_present || ent_leaf) ? ST_DONE : ST_ISSUE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            base_q  <= '0;
            vaddr_q <= '0;
            four_q  <= 1'b0;
            paddr_q <= '0;
            size_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    four_q  <= long_mode;
                    paddr_q <= '0;
                    size_q  <= '0;
                    fault_q <= 1'b0;
                    if (!paging_en) begin
                        paddr_q <= req_vaddr;
                    end else if (long_mode && !canon) begin
                        fault_q <= 1'b1;
                    end else if (long_mode) begin
                        level_q <= LONG_TOP;
                        base_q  <= cr3 & ROOT_MASK;
                    end else begin
                        level_q <= SHORT_TOP;
                        base_q  <= cr3 & SHORT_ROOT_MASK;
                    end
                end
                ST_WAIT: if (mem_rvalid) begin
                    if (!ent_present) begin
                        fault_q <= 1'b1;
                    end else if (ent_leaf) begin
                        paddr_q <= ent_paddr;
                        size_q  <= level_q;
                    end else begin
                        base_q  <= ent_next;
                        level_q <= level_q - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_ISSUE);
        mem_addr  = fetch_addr;
        rsp_valid = (state_q == ST_DONE);
        rsp_paddr = paddr_q;
        rsp_size  = size_q;
        rsp_fault = fault_q;
    end

    // Checks
    assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_no_read_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !req_ready) |=> !mem_req);
    assert_fetch_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & ~a20_mask) == '0));
    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_walk_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rvalid) |=> (mem_req || rsp_valid));
    assert_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=>
        (rsp_valid && !rsp_fault && rsp_paddr == $past(req_vaddr) && !mem_req));
    assert_noncanon_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && paging_en && long_mode &&
         !((&req_vaddr[ENTRY_W-1:VA_W-1]) || !(|req_vaddr[ENTRY_W-1:VA_W-1])))
        |=> (rsp_valid && rsp_fault && !mem_req));
    assert_gig_four_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && rsp_size == SHORT_TOP) |-> four_q);
endmodule

// File: tb/page_walk_engine_tb.sv
module page_walk_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [63:0] cr3 = '0;
    logic        long_mode = 1'b1;
    logic        paging_en = 1'b1;
    logic [63:0] a20_mask = '1;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_paddr;
    logic [1:0]  rsp_size;
    logic        rsp_fault;

    always #2 clk = ~clk;

    page_walk_engine u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .cr3(cr3), .long_mode(long_mode), .paging_en(paging_en),
        .a20_mask(a20_mask), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_size(rsp_size), .rsp_fault(rsp_fault)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lat = 1;
    int rv_cyc = 0;
    bit finished = 0;
    logic [63:0] mem_arr [logic [63:0]];
    logic [63:0] exp_q [$];

    localparam logic [63:0] BM = 64'h000F_FFFF_FFFF_F000;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem_arr.exists(a) ? mem_arr[a] : 64'h0;
    endfunction

    function automatic int idx_of(input logic [63:0] va, input int lvl, input bit lm);
        if (!lm && lvl == 2) return int'(va[31:30]);
        return int'((va >> (12 + 9 * lvl)) & 64'h1ff);
    endfunction

    task automatic put(input logic [63:0] base, input int idx, input logic [63:0] v);
        mem_arr[base + 64'(idx) * 8] = v;
    endtask

    // Behavioural walk: fills exp_q with fetch addresses and returns the result
    task automatic ref_walk(input logic [63:0] va, output logic [63:0] pa,
                            output int sz, output bit flt);
        logic [63:0] base, a, e, m;
        int lvl;
        exp_q.delete();
        pa = 0; sz = 0; flt = 0;
        if (!paging_en) begin pa = va; return; end
        if (long_mode && !(va[63:47] == '0 || va[63:47] == '1)) begin flt = 1; return; end
        base = long_mode ? (cr3 & BM) : (cr3 & ~64'h1f);
        lvl  = long_mode ? 3 : 2;
        forever begin
            a = (base + 64'(idx_of(va, lvl, long_mode)) * 8) & a20_mask;
            exp_q.push_back(a);
            e = rd(a);
            if (!e[0]) begin flt = 1; return; end
            if (lvl == 0 || (e[7] && (lvl == 1 || (lvl == 2 && long_mode)))) begin
                m  = (64'd1 << (12 + 9 * lvl)) - 1;
                pa = (e & ~m & ~(64'd1 << 63)) | (va & m);
                sz = lvl;
                return;
            end
            base = e & BM;
            lvl--;
        end
    endtask

    // Memory responder and fetch-address monitor
    initial begin
        bit pend = 0;
        int cnt = 0;
        logic [63:0] paddr_p = 0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend) begin
                if (cnt <= 1) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd(paddr_p);
                    rv_cyc     = cyc;
                    pend       = 0;
                end else cnt--;
            end
            if (mem_req && rst_n) begin
                chk(!pend, "R10", "read while one outstanding", 64'(pend), 64'd0);
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected fetch", mem_addr, 64'd0);
                end else begin
                    chk(mem_addr == exp_q[0], "R3", "fetch address", mem_addr, exp_q[0]);
                    chk((mem_addr & ~a20_mask) == 0, "R5", "fetch wrap mask", mem_addr, mem_addr & a20_mask);
                    void'(exp_q.pop_front());
                end
                pend = 1; cnt = lat; paddr_p = mem_addr;
            end
        end
    end

    task automatic do_walk(input logic [63:0] va, input string tag, input int lat_i,
                           input bit intrude);
        logic [63:0] epa;
        int esz, start, t;
        bit eflt, nreads;
        lat = lat_i;
        ref_walk(va, epa, esz, eflt);
        nreads = (exp_q.size() != 0);
        @(negedge clk);
        chk(req_ready, "R10", {tag, " ready when idle"}, 64'(req_ready), 64'd1);
        req_vaddr = va; req_valid = 1'b1; start = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 100) begin
            if (intrude && t == 1) begin req_valid = 1'b1; req_vaddr = 64'h0000_0000_DEAD_0000; end
            if (intrude && t == 2) req_valid = 1'b0;
            chk(!(intrude && t == 1 && req_ready), "R10", {tag, " ready while busy"}, 64'(req_ready), 64'd0);
            @(negedge clk); t++;
        end
        req_valid = 1'b0;
        chk(rsp_valid, tag, "response seen", 64'(rsp_valid), 64'd1);
        chk(rsp_fault == eflt, tag, "fault", 64'(rsp_fault), 64'(eflt));
        if (!eflt) begin
            chk(rsp_paddr == epa, tag, "paddr", rsp_paddr, epa);
            chk(int'(rsp_size) == esz, tag, "size", 64'(rsp_size), 64'(esz));
        end
        chk(exp_q.size() == 0, tag, "reads left", 64'(exp_q.size()), 64'd0);
        if (nreads) chk(cyc == rv_cyc + 1, "R11", {tag, " rsp timing"}, 64'(cyc), 64'(rv_cyc + 1));
        else        chk(cyc == start + 1, tag, "rsp timing no-read", 64'(cyc), 64'(start + 1));
        @(negedge clk);
        chk(!rsp_valid, "R11", {tag, " rsp one cycle"}, 64'(rsp_valid), 64'd0);
        if (intrude) begin
            repeat (4) begin
                @(negedge clk);
                chk(!mem_req && !rsp_valid, "R10", "ignored request started nothing",
                    64'({mem_req, rsp_valid}), 64'd0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] va;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req && !rsp_valid, "R11", "reset state",
            64'({req_ready, mem_req, rsp_valid}), 64'b100);

        // R1: pass-through
        paging_en = 1'b0;
        do_walk(64'hDEAD_BEEF_0000_1234, "R1", 1, 0);
        paging_en = 1'b1;

        // R2: non-canonical
        long_mode = 1'b1;
        do_walk(64'h0000_8000_0000_0000, "R2", 1, 0);
        do_walk(64'h7FFF_0000_0000_0000, "R2", 1, 0);

        // R3 / R9: four-level 4 KiB walk, NX set in entries
        cr3 = 64'h8000_0000_0000_1ABC;
        va  = 64'h0000_1234_5678_9ABC;
        put(64'h1000, idx_of(va, 3, 1), 64'h8000_0000_0000_2003);
        put(64'h2000, idx_of(va, 2, 1), 64'h0000_0000_0000_3003);
        put(64'h3000, idx_of(va, 1, 1), 64'h0000_0000_0000_4003);
        put(64'h4000, idx_of(va, 0, 1), 64'h8000_0000_00AB_C003);
        do_walk(va, "R9", 1, 0);
        do_walk(va, "R3", 3, 0);

        // R3: upper-half canonical address
        cr3 = 64'h0000_0000_0001_0000;
        va  = 64'hFFFF_8000_0040_1555;
        put(64'h10000, idx_of(va, 3, 1), 64'h0000_0000_0001_1001);
        put(64'h11000, idx_of(va, 2, 1), 64'h0000_0000_0001_2001);
        put(64'h12000, idx_of(va, 1, 1), 64'h0000_0000_0001_3001);
        put(64'h13000, idx_of(va, 0, 1), 64'h0000_0007_7777_7001);
        do_walk(va, "R3", 2, 0);

        // R7: 1 GiB leaf
        cr3 = 64'h0000_0000_0002_0000;
        va  = 64'h0000_0040_3ABC_DEF0;
        put(64'h20000, idx_of(va, 3, 1), 64'h0000_0000_0002_1003);
        put(64'h21000, idx_of(va, 2, 1), 64'h8000_0001_7FFF_F083);
        do_walk(va, "R7", 2, 0);

        // R8: 2 MiB leaf in four-level mode
        cr3 = 64'h0000_0000_0003_0000;
        va  = 64'h0000_0001_4035_4321;
        put(64'h30000, idx_of(va, 3, 1), 64'h0000_0000_0003_1003);
        put(64'h31000, idx_of(va, 2, 1), 64'h0000_0000_0003_2003);
        put(64'h32000, idx_of(va, 1, 1), 64'h8000_0000_05FF_FF83);
        do_walk(va, "R8", 1, 0);

        // R6: not present at top and at last level
        cr3 = 64'h0000_0000_0004_0000;
        do_walk(64'h0000_0000_1234_5000, "R6", 1, 0);
        cr3 = 64'h0000_0000_0005_0000;
        va  = 64'h0000_0000_0060_7000;
        put(64'h50000, idx_of(va, 3, 1), 64'h0000_0000_0005_1003);
        put(64'h51000, idx_of(va, 2, 1), 64'h0000_0000_0005_2003);
        put(64'h52000, idx_of(va, 1, 1), 64'h0000_0000_0005_3003);
        put(64'h53000, idx_of(va, 0, 1), 64'h0000_0000_0099_9002);
        do_walk(va, "R6", 2, 0);

        // R5: wrap mask clears bit 20 of every fetch
        a20_mask = ~(64'd1 << 20);
        cr3 = 64'h0000_0000_0016_0000;
        va  = 64'h0000_0000_0080_9010;
        put(64'h60000, idx_of(va, 3, 1), 64'h0000_0000_0016_1003);
        put(64'h61000, idx_of(va, 2, 1), 64'h0000_0000_0016_2003);
        put(64'h62000, idx_of(va, 1, 1), 64'h0000_0000_0016_3003);
        put(64'h63000, idx_of(va, 0, 1), 64'h0000_0000_0123_4003);
        do_walk(va, "R5", 1, 0);
        a20_mask = '1;

        // R4: three-level mode, top bit 7 ignored, 4 KiB and 2 MiB
        long_mode = 1'b0;
        cr3 = 64'h0000_0000_0007_0F3F;
        va  = 64'h0000_0000_C040_3123;
        put(64'h70F20, idx_of(va, 2, 0), 64'h0000_0000_0000_8083);
        put(64'h8000,  idx_of(va, 1, 0), 64'h0000_0000_0000_9003);
        put(64'h9000,  idx_of(va, 0, 0), 64'h8000_0000_0123_4003);
        do_walk(va, "R4", 2, 0);
        va  = 64'h0000_0000_C0A5_4321;
        put(64'h8000,  idx_of(va, 1, 0), 64'h8000_0000_00A0_0083);
        do_walk(va, "R8", 1, 0);
        long_mode = 1'b1;

        // R10: request during a walk is ignored
        cr3 = 64'h8000_0000_0000_1ABC;
        do_walk(64'h0000_1234_5678_9ABC, "R10", 3, 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule